// File: doc/BRIEF.md
# Fast Eight-Point Forward Cosine Transform Pipeline

This block takes eight signed samples in parallel and returns their eight cosine-transform coefficients after a fixed four-cycle pipeline. It accepts one new sample vector on every clock. A strobe marks each vector on the way in and each coefficient set on the way out. It is meant to serve as the one-dimensional kernel of an image or video transform, where an outer sequencer feeds it rows or columns.

The datapath does not form a full eight-by-eight product. First it folds the input into mirror sums and mirror differences. The sums feed only the even coefficients and the differences feed only the odd ones. The even half uses a second sum/difference layer, a shared scaling by cos(pi/4) and one plane rotation. The odd half uses two plane rotations, a layer of sum/difference butterflies and two more scalings by cos(pi/4). Each rotation is built from three constant multipliers instead of four. The whole transform therefore needs thirteen constant multipliers. The cosine constants carry twelve fractional bits. Intermediate values are kept at full precision, and rounding happens only once, at the output.

Top module: `dct8_fast`

## Requirements
- R1: out_valid is high on the clock cycle that follows the fourth rising edge after a vector is sampled with in_valid high, and is low otherwise. Vectors may arrive on consecutive cycles, and each one produces exactly one result.
- R2: rst_n is an asynchronous active-low reset. While it is low, out_valid is low, and out_valid drops at once when rst_n falls, without waiting for a clock edge.
- R3: Each output y(k) is within 2 LSB of e_k times the sum over n = 0..7 of x(n)*cos((2n+1)k*pi/16), where e_0 = cos(pi/4) and e_k = 1 for k > 0.
- R4: Sample x(n) is the two's-complement field x_flat[n*IN_W +: IN_W]. Coefficient y(k) is the two's-complement field y_flat[k*OUT_W +: OUT_W].
- R5: An input with x(n) = x(7-n) for all n gives y(1), y(3), y(5) and y(7) exactly zero.
- R6: An input with x(n) = -x(7-n) for all n gives y(0), y(2), y(4) and y(6) exactly zero.
- R7: While out_valid is low, y_flat keeps the last result it showed. Cycles with in_valid low do not change it.
- R8: When all eight samples are equal to v, y(0) is within 2 LSB of 8*v*cos(pi/4), and every other coefficient is exactly zero.
- R9: Full-scale inputs (all samples -2048, or samples alternating between +2047 and -2048) meet R3 without wrapping in the 16-bit result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| in_valid | input | 1 | Marks x_flat as a vector to transform |
| x_flat | input | 8*IN_W | Eight packed signed samples, x(0) in the low field |
| out_valid | output | 1 | Marks y_flat as a new coefficient set |
| y_flat | output | 8*OUT_W | Eight packed signed coefficients, y(0) in the low field |

## Verification
The assertions assume that in_valid and x_flat carry defined values on every edge after reset. They also assume that no result is expected until four edges have passed since reset, and a small counter in the checker gates the latency and symmetry properties on that. The mirror properties assume the input pair sums are computed without wrapping, so the stimulus builds antisymmetric vectors only from values in -2047..2047. The stimulus holds in_valid low throughout reset, drives every sample field on every cycle, and mixes directed vectors (constant, full-scale, impulse, mirrored) with back-to-back and gapped random vectors.

// File: rtl/dct8_pkg.sv
package dct8_pkg;
  // Cosine constants cos(i*pi/16), rounded to COS_FRAC fractional bits.
  // COS_W leaves room for the sum of two constants inside a rotator.
  localparam int COS_FRAC = 12;
  localparam int COS_W    = 14;
  localparam int C1 = 4017;
  localparam int C2 = 3784;
  localparam int C3 = 3406;
  localparam int C4 = 2896;
  localparam int C5 = 2276;
  localparam int C6 = 1567;
  localparam int C7 = 799;
endpackage

// File: rtl/dct8_rot.sv
// Plane rotation r0 = CA*x0 + CB*x1, r1 = CB*x0 - CA*x1 using three products.
module dct8_rot #(
  parameter int W  = 13,
  parameter int CW = 14,
  parameter int CA = 0,
  parameter int CB = 0,
  localparam int OW = W + CW + 2
) (
  input  logic signed [W-1:0]  x0,
  input  logic signed [W-1:0]  x1,
  output logic signed [OW-1:0] r0,
  output logic signed [OW-1:0] r1
);
  logic signed [OW-1:0] ex0, ex1, k_b, k_dif, k_sum, shared;

  assign ex0    = OW'(x0);
  assign ex1    = OW'(x1);
  assign k_b    = OW'(CB);
  assign k_dif  = OW'(CA - CB);
  assign k_sum  = OW'(CA + CB);
  assign shared = k_b * (ex0 + ex1);
  assign r0     = shared + k_dif * ex0;
  assign r1     = shared - k_sum * ex1;
endmodule

// File: rtl/dct8_rnd.sv
// Round half up by SH fractional bits, keep OW result bits.
module dct8_rnd #(
  parameter int IW = 45,
  parameter int SH = 12,
  parameter int OW = 16
) (
  input  logic signed [IW-1:0] d,
  output logic signed [OW-1:0] q
);
  localparam logic signed [IW:0] HALF = {{IW{1'b0}}, 1'b1} << (SH - 1);

  logic signed [IW:0] t;

  assign t = {d[IW-1], d} + HALF;
  assign q = OW'(t >>> SH);
endmodule

// File: rtl/dct8_fast.sv
module dct8_fast #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [8*IN_W-1:0]  x_flat,
  output logic               out_valid,
  output logic [8*OUT_W-1:0] y_flat
);
  import dct8_pkg::*;

  localparam int NPT    = 8;
  localparam int HALF_N = NPT / 2;
  localparam int STAGES = 4;
  localparam int CW     = COS_W;
  localparam int FRAC   = COS_FRAC;
  localparam int PW     = IN_W + 1;     // mirror sums / differences
  localparam int EW     = IN_W + 2;     // second even layer
  localparam int AW     = PW + CW + 2;  // odd rotator outputs
  localparam int QW     = EW + CW + 2;  // even products
  localparam int UW     = AW + 2;       // stage-3 register width
  localparam int ZW     = UW + CW;      // pre-rounding width

  // ---------------- valid pipeline ----------------
  logic [STAGES-1:0] vld_q, vld_nx;

  always_comb vld_nx = {vld_q[STAGES-2:0], in_valid};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_nx;
  end

  assign out_valid = vld_q[STAGES-1];

  // ---------------- stage 1: mirror butterflies ----------------
  logic signed [IN_W-1:0] xs   [NPT];
  logic signed [PW-1:0]   p_nx [HALF_N];
  logic signed [PW-1:0]   m_nx [HALF_N];
  logic signed [PW-1:0]   p_q  [HALF_N];
  logic signed [PW-1:0]   m_q  [HALF_N];

  for (genvar n = 0; n < NPT; n++) begin : g_unpack
    assign xs[n] = $signed(x_flat[n*IN_W +: IN_W]);
  end

  for (genvar i = 0; i < HALF_N; i++) begin : g_fly
    assign p_nx[i] = PW'(xs[i]) + PW'(xs[NPT-1-i]);
    assign m_nx[i] = PW'(xs[i]) - PW'(xs[NPT-1-i]);
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      p_q <= p_nx;
      m_q <= m_nx;
    end
  end

  // ---------------- stage 2: even layer, odd rotations ----------------
  logic signed [EW-1:0] es0_nx, es1_nx, ed0_nx, ed1_nx;
  logic signed [EW-1:0] es0_q, es1_q, ed0_q, ed1_q;
  logic signed [AW-1:0] oa_nx, ob_nx, oc_nx, od_nx;
  logic signed [AW-1:0] oa_q, ob_q, oc_q, od_q;

  always_comb begin
    es0_nx = EW'(p_q[0]) + EW'(p_q[3]);
    es1_nx = EW'(p_q[1]) + EW'(p_q[2]);
    ed0_nx = EW'(p_q[0]) - EW'(p_q[3]);
    ed1_nx = EW'(p_q[1]) - EW'(p_q[2]);
  end

  dct8_rot #(.W(PW), .CW(CW), .CA(C5), .CB(C3)) u_rot_outer (
    .x0(m_q[0]), .x1(m_q[3]), .r0(oa_nx), .r1(od_nx)
  );

  dct8_rot #(.W(PW), .CW(CW), .CA(C7), .CB(C1)) u_rot_inner (
    .x0(m_q[1]), .x1(m_q[2]), .r0(ob_nx), .r1(oc_nx)
  );

  always_ff @(posedge clk) begin
    if (vld_q[0]) begin
      es0_q <= es0_nx;
      es1_q <= es1_nx;
      ed0_q <= ed0_nx;
      ed1_q <= ed1_nx;
      oa_q  <= oa_nx;
      ob_q  <= ob_nx;
      oc_q  <= oc_nx;
      od_q  <= od_nx;
    end
  end

  // ---------------- stage 3: even products, odd butterflies ----------------
  logic signed [QW-1:0] ev_y2, ev_y6, esum, edif, kc4;
  logic signed [UW-1:0] r3_nx [NPT];
  logic signed [UW-1:0] r3_q  [NPT];

  dct8_rot #(.W(EW), .CW(CW), .CA(C2), .CB(C6)) u_rot_even (
    .x0(ed0_q), .x1(ed1_q), .r0(ev_y2), .r1(ev_y6)
  );

  always_comb begin
    kc4      = QW'(C4);
    esum     = QW'(es0_q) + QW'(es1_q);
    edif     = QW'(es0_q) - QW'(es1_q);
    r3_nx[0] = UW'(esum * kc4);
    r3_nx[4] = UW'(edif * kc4);
    r3_nx[2] = UW'(ev_y2);
    r3_nx[6] = UW'(ev_y6);
    r3_nx[3] = UW'(od_q) - UW'(ob_q);
    r3_nx[5] = UW'(oa_q) - UW'(oc_q);
    r3_nx[1] = UW'(oa_q) + UW'(oc_q) + UW'(od_q) + UW'(ob_q);
    r3_nx[7] = UW'(od_q) + UW'(ob_q) - UW'(oa_q) - UW'(oc_q);
  end

  always_ff @(posedge clk) begin
    if (vld_q[1]) r3_q <= r3_nx;
  end

  // ---------------- stage 4: final scaling, rounding ----------------
  logic signed [ZW-1:0]    z    [NPT];
  logic signed [OUT_W-1:0] y_nx [NPT];
  logic signed [OUT_W-1:0] y_q  [NPT];

  for (genvar k = 0; k < NPT; k++) begin : g_out
    localparam bit SCALED = (k == 1) || (k == 7);
    if (SCALED) begin : g_scl
      assign z[k] = ZW'(r3_q[k]) * ZW'(C4);
    end else begin : g_pass
      assign z[k] = ZW'(r3_q[k]);
    end
    dct8_rnd #(.IW(ZW), .SH(SCALED ? 2*FRAC : FRAC), .OW(OUT_W)) u_rnd (
      .d(z[k]), .q(y_nx[k])
    );
    assign y_flat[k*OUT_W +: OUT_W] = y_q[k];
  end

  always_ff @(posedge clk) begin
    if (vld_q[2]) y_q <= y_nx;
  end
endmodule

// File: rtl/dct8_fast_chk.sv
module dct8_fast_chk #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [8*IN_W-1:0]  x_flat,
  input logic               out_valid,
  input logic [8*OUT_W-1:0] y_flat
);
  logic [2:0] since_q;
  logic       seen_q;
  logic       warm;
  logic       mirror, anti;
  logic       odd_zero, even_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else begin
      if (since_q != 3'd4) since_q <= since_q + 3'd1;
      if (out_valid)       seen_q  <= 1'b1;
    end
  end

  assign warm = (since_q == 3'd4);

  always_comb begin
    mirror = 1'b1;
    anti   = 1'b1;
    for (int i = 0; i < 4; i++) begin
      if (int'($signed(x_flat[i*IN_W +: IN_W])) != int'($signed(x_flat[(7-i)*IN_W +: IN_W])))
        mirror = 1'b0;
      if (int'($signed(x_flat[i*IN_W +: IN_W])) + int'($signed(x_flat[(7-i)*IN_W +: IN_W])) != 0)
        anti = 1'b0;
    end
    odd_zero  = 1'b1;
    even_zero = 1'b1;
    for (int k = 0; k < 8; k += 2) begin
      if (y_flat[k*OUT_W +: OUT_W] != '0)     even_zero = 1'b0;
      if (y_flat[(k+1)*OUT_W +: OUT_W] != '0) odd_zero  = 1'b0;
    end
  end

  // R1: a result appears exactly four edges after its vector is taken
  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (out_valid == $past(in_valid, 4)));

  // R2: no result is flagged while reset is held
  always @(posedge clk) begin
    if (!rst_n) a_r2_reset_idle: assert (!out_valid);
  end

  // R5: mirrored input leaves every odd coefficient at zero
  a_r5_mirror_odd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid && $past(in_valid && mirror, 4)) |-> odd_zero);

  // R6: antimirrored input leaves every even coefficient at zero
  a_r6_anti_even_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid && $past(in_valid && anti, 4)) |-> even_zero);

  // R7: coefficients hold while no new result is flagged
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !out_valid) |-> $stable(y_flat));
endmodule

bind dct8_fast dct8_fast_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (.*);

// File: tb/dct8_fast_test.sv
module dct8_fast_test;
  localparam int  CLK_PERIOD = 10;
  localparam int  IN_W  = 12;
  localparam int  OUT_W = 16;
  localparam real TOL   = 2.0;
  localparam real PI    = 3.14159265358979;

  logic               clk;
  logic               rst_n;
  logic               in_valid;
  logic [8*IN_W-1:0]  x_flat;
  logic               out_valid;
  logic [8*OUT_W-1:0] y_flat;

  int checks;
  int errors;
  bit done;

  bit                 q_v[$];
  logic [8*IN_W-1:0]  q_x[$];
  logic [8*OUT_W-1:0] last_y;
  bit                 have_last;

  dct8_fast #(.IN_W(IN_W), .OUT_W(OUT_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_flat(x_flat),
    .out_valid(out_valid), .y_flat(y_flat)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // R4: field packing of samples and coefficients
  function automatic int xget(logic [8*IN_W-1:0] v, int n);
    return int'($signed(v[n*IN_W +: IN_W]));
  endfunction

  function automatic int yget(logic [8*OUT_W-1:0] v, int k);
    return int'($signed(v[k*OUT_W +: OUT_W]));
  endfunction

  function automatic logic [8*IN_W-1:0] pack8(int a[8]);
    logic [8*IN_W-1:0] v;
    for (int n = 0; n < 8; n++) v[n*IN_W +: IN_W] = IN_W'(a[n]);
    return v;
  endfunction

  function automatic logic [8*IN_W-1:0] rand_vec();
    logic [8*IN_W-1:0] v;
    for (int n = 0; n < 8; n++) v[n*IN_W +: IN_W] = IN_W'($urandom);
    return v;
  endfunction

  // R3: direct matrix-product reference
  function automatic real ref_y(logic [8*IN_W-1:0] v, int k);
    real acc;
    acc = 0.0;
    for (int n = 0; n < 8; n++)
      acc += $itor(xget(v, n)) * $cos($itor((2*n+1)*k) * PI / 16.0);
    if (k == 0) acc = acc * $cos(PI / 4.0);
    return acc;
  endfunction

  task automatic check_int(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic compare();
    bit                ev;
    logic [8*IN_W-1:0] ex;
    bit                sym, anti, flat;
    ev = q_v.pop_front();
    ex = q_x.pop_front();
    check_int("R1 out_valid", int'(out_valid), int'(ev));
    if (ev) begin
      sym = 1; anti = 1; flat = 1;
      for (int i = 0; i < 4; i++) begin
        if (xget(ex, i) != xget(ex, 7-i))     sym  = 0;
        if (xget(ex, i) + xget(ex, 7-i) != 0) anti = 0;
      end
      for (int n = 1; n < 8; n++) if (xget(ex, n) != xget(ex, 0)) flat = 0;
      for (int k = 0; k < 8; k++) begin
        real r, d;
        r = ref_y(ex, k);
        d = $itor(yget(y_flat, k)) - r;
        checks++;
        if (d > TOL || d < -TOL) begin
          errors++;
          $display("FAIL R3 y(%0d) got %0d expected %f", k, yget(y_flat, k), r);
        end
      end
      if (sym)  for (int k = 1; k < 8; k += 2) check_int("R5 odd coefficient", yget(y_flat, k), 0);
      if (anti) for (int k = 0; k < 8; k += 2) check_int("R6 even coefficient", yget(y_flat, k), 0);
      if (flat) for (int k = 1; k < 8; k++)    check_int("R8 non-DC coefficient", yget(y_flat, k), 0);
      last_y    = y_flat;
      have_last = 1;
    end else if (have_last) begin
      checks++;
      if (y_flat !== last_y) begin
        errors++;
        $display("FAIL R7 y_flat got %h expected %h", y_flat, last_y);
      end
    end
  endtask

  task automatic cyc(bit v, logic [8*IN_W-1:0] x);
    @(negedge clk);
    compare();
    q_v.push_back(v);
    q_x.push_back(x);
    in_valid = v;
    x_flat   = x;
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    rst_n    = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check_int("R2 out_valid in reset", int'(out_valid), 0);
    end
    rst_n = 1'b1;
    q_v.delete();
    q_x.delete();
    repeat (4) begin
      q_v.push_back(1'b0);
      q_x.push_back('0);
    end
    have_last = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int a[8];
    checks = 0; errors = 0; done = 0; have_last = 0;
    rst_n = 1'b0; in_valid = 1'b0; x_flat = '0;
    do_reset();

    // R8: constant input
    for (int n = 0; n < 8; n++) a[n] = 100;
    cyc(1, pack8(a));
    // R9: full-scale negative and alternating extremes
    for (int n = 0; n < 8; n++) a[n] = -2048;
    cyc(1, pack8(a));
    for (int n = 0; n < 8; n++) a[n] = (n % 2 == 0) ? 2047 : -2048;
    cyc(1, pack8(a));
    // R3: impulse at x(0), then at x(5)
    for (int n = 0; n < 8; n++) a[n] = (n == 0) ? 2047 : 0;
    cyc(1, pack8(a));
    for (int n = 0; n < 8; n++) a[n] = (n == 5) ? -1500 : 0;
    cyc(1, pack8(a));
    // R7: idle gap holds the last result
    repeat (6) cyc(0, rand_vec());

    // R5: mirrored vectors
    repeat (20) begin
      for (int i = 0; i < 4; i++) begin
        a[i]   = int'($urandom_range(4095)) - 2048;
        a[7-i] = a[i];
      end
      cyc(1, pack8(a));
    end
    // R6: antimirrored vectors
    repeat (20) begin
      for (int i = 0; i < 4; i++) begin
        a[i]   = int'($urandom_range(4094)) - 2047;
        a[7-i] = -a[i];
      end
      cyc(1, pack8(a));
    end

    // R1, R3: back-to-back random vectors
    repeat (300) cyc(1, rand_vec());
    // R1, R3, R7: random vectors with gaps
    repeat (2000) cyc(($urandom % 4) != 0, rand_vec());

    // R2: reset mid-stream drops out_valid without a clock edge
    repeat (5) cyc(1, rand_vec());
    #1 rst_n = 1'b0;
    #1 check_int("R2 asynchronous clear", int'(out_valid), 0);
    do_reset();

    repeat (50) cyc(1, rand_vec());
    repeat (6)  cyc(0, rand_vec());

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule